// File: doc/BRIEF.md
# 16-bit Operand Address Stage

This block sits after instruction decode in a 16-bit processor core. It receives the mode, register and register/memory fields of an operand specifier byte, the width bit, a 16-bit displacement field, a one-hot segment override and the current contents of the four address registers and three segment registers. It then decides whether the operand lives in a register or in memory.

For a memory operand the block forms the 16-bit effective address from an optional base register, an optional index register and an optional signed displacement. It picks the segment: the stack segment when the base pointer is involved, the data segment otherwise, and any override input wins over both. It then produces the 20-bit physical address. In the same cycle it decodes the register field, and for register forms the register/memory field, into a selector that names a 16-bit register and, for byte operands, which half of it is used.

All results are captured in one register stage. The stage has a valid in and a valid out, and it holds its results while no new operand is presented.

Top module: `modrm_ea_stage`

## Requirements
- R1: When mode = 3 the operand is a register: is_mem = 0, and ea, phys and seg_id are all 0. Every other mode gives is_mem = 1.
- R2: For memory forms the register/memory field selects the terms: 0 BX+SI, 1 BX+DI, 2 BP+SI, 3 BP+DI, 4 SI, 5 DI, 6 BP, 7 BX. With mode 0 no displacement is added. The sum wraps modulo 2^16.
- R3: Mode 1 adds disp[7:0] sign-extended to 16 bits. Mode 2 adds all 16 bits of disp.
- R4: Mode 0 with register/memory field 6 is a direct address: ea = disp, with no base and no index, and the default segment is the data segment.
- R5: seg_id codes are 0 = data, 1 = stack, 2 = extra. With no override, forms that use BP as base give 1 and all other memory forms give 0.
- R6: seg_ovr is one-hot with bit 2 = extra, bit 1 = stack, bit 0 = data. When more than one bit is set, the highest set bit wins. The override has no effect on register forms.
- R7: phys = (selected segment value × 16 + ea) modulo 2^20.
- R8: Register field decode. With wide = 1: reg_code = reg and reg_hi = 0. With wide = 0: reg_code = {0, reg[1:0]} and reg_hi = reg[2]. So code 0..3 means AX,CX,DX,BX and code 4..7 means SP,BP,SI,DI.
- R9: For mode = 3 the register/memory field is decoded into rm_code and rm_hi with the R8 mapping. For memory forms both are 0.
- R10: out_valid equals in_valid from the previous edge. Result outputs load only on an edge where in_valid = 1 and otherwise hold their value.
- R11: While rst_n is low, out_valid and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand fields present this cycle |
| mode | input | 2 | Addressing mode field |
| reg_f | input | 3 | Register field |
| rm_f | input | 3 | Register/memory field |
| wide | input | 1 | 1 = 16-bit operand, 0 = byte operand |
| disp | input | 16 | Displacement field (low byte used in mode 1) |
| seg_ovr | input | 3 | One-hot segment override: [2] extra, [1] stack, [0] data |
| bx_v | input | 16 | BX contents |
| bp_v | input | 16 | BP contents |
| si_v | input | 16 | SI contents |
| di_v | input | 16 | DI contents |
| ds_v | input | 16 | Data segment |
| ss_v | input | 16 | Stack segment |
| es_v | input | 16 | Extra segment |
| out_valid | output | 1 | Results valid |
| is_mem | output | 1 | Operand is in memory |
| ea | output | 16 | Effective address |
| seg_id | output | 2 | Segment used (0 data, 1 stack, 2 extra) |
| phys | output | 20 | Physical address |
| reg_code | output | 3 | Decoded register field |
| reg_hi | output | 1 | Register field names an upper byte |
| rm_code | output | 3 | Decoded register/memory field (register forms) |
| rm_hi | output | 1 | Register/memory field names an upper byte |

## Verification
The bench targets several corner cases, and each one catches a specific kind of error:
- Negative 8-bit displacements. A design that zero-extends them lands 256 bytes high.
- Base+index sums that pass FFFFh. A wide adder would carry into the physical address.
- Segment values near FFFFh, where the physical address must fold to 20 bits.
- The direct-address form. It is the one place where field value 6 must not pull in BP, and it must not switch to the stack segment.
- BP-based forms with and without overrides, and with several override bits set. These expose a wrong default segment or a wrong override priority.
- Register forms with an override. These check that the override is ignored.
- Idle cycles with changed inputs. A stage that loads without valid would show new values.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int EA_W      = 16;
  localparam int SEG_SHIFT = 4;
  localparam int SEL_W     = 3;

  typedef enum logic [1:0] {
    SEG_DS = 2'd0,
    SEG_SS = 2'd1,
    SEG_ES = 2'd2
  } seg_e;
endpackage

// File: rtl/ea_calc.sv
module ea_calc #(
  parameter int AW = 16
) (
  input  logic [1:0]    mode,
  input  logic [2:0]    rm_f,
  input  logic [AW-1:0] disp,
  input  logic [AW-1:0] bx_v,
  input  logic [AW-1:0] bp_v,
  input  logic [AW-1:0] si_v,
  input  logic [AW-1:0] di_v,
  output logic          is_mem,
  output logic          bp_used,
  output logic [AW-1:0] ea
);
  function automatic logic [AW-1:0] sext8(input logic [AW-1:0] d);
    return {{(AW-8){d[7]}}, d[7:0]};
  endfunction

  logic          direct;
  logic [AW-1:0] base_t, idx_t, disp_t;
  logic          bp_base;

  always_comb begin
    direct  = (mode == 2'd0) && (rm_f == 3'd6);
    base_t  = '0;
    idx_t   = '0;
    bp_base = 1'b0;
    case (rm_f)
      3'd0: begin base_t = bx_v; idx_t = si_v; end
      3'd1: begin base_t = bx_v; idx_t = di_v; end
      3'd2: begin base_t = bp_v; idx_t = si_v; bp_base = 1'b1; end
      3'd3: begin base_t = bp_v; idx_t = di_v; bp_base = 1'b1; end
      3'd4: idx_t = si_v;
      3'd5: idx_t = di_v;
      3'd6: begin
        if (!direct) begin base_t = bp_v; bp_base = 1'b1; end
      end
      default: base_t = bx_v;
    endcase
    case (mode)
      2'd0:    disp_t = direct ? disp : '0;
      2'd1:    disp_t = sext8(disp);
      2'd2:    disp_t = disp;
      default: disp_t = '0;
    endcase
    is_mem  = (mode != 2'd3);
    bp_used = is_mem && bp_base;
    ea      = is_mem ? (base_t + idx_t + disp_t) : '0;
  end
endmodule

// File: rtl/seg_pick.sv
module seg_pick import ea_pkg::*; #(
  parameter int AW = 16
) (
  input  logic          is_mem,
  input  logic          bp_used,
  input  logic [2:0]    seg_ovr,
  input  logic [AW-1:0] ds_v,
  input  logic [AW-1:0] ss_v,
  input  logic [AW-1:0] es_v,
  output seg_e          seg_id,
  output logic [AW-1:0] seg_val
);
  always_comb begin
    if (!is_mem)         seg_id = SEG_DS;
    else if (seg_ovr[2]) seg_id = SEG_ES;
    else if (seg_ovr[1]) seg_id = SEG_SS;
    else if (seg_ovr[0]) seg_id = SEG_DS;
    else if (bp_used)    seg_id = SEG_SS;
    else                 seg_id = SEG_DS;
    case (seg_id)
      SEG_SS:  seg_val = ss_v;
      SEG_ES:  seg_val = es_v;
      default: seg_val = ds_v;
    endcase
  end
endmodule

// File: rtl/reg_decode.sv
module reg_decode #(
  parameter int SW = 3
) (
  input  logic          en,
  input  logic          wide,
  input  logic [SW-1:0] field,
  output logic [SW-1:0] code,
  output logic          hi
);
  always_comb begin
    if (!en) begin
      code = '0;
      hi   = 1'b0;
    end else if (wide) begin
      code = field;
      hi   = 1'b0;
    end else begin
      code = {1'b0, field[SW-2:0]};
      hi   = field[SW-1];
    end
  end
endmodule

// File: rtl/modrm_ea_stage.sv
module modrm_ea_stage import ea_pkg::*; #(
  parameter int AW = EA_W,
  parameter int SH = SEG_SHIFT,
  parameter int SW = SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       mode,
  input  logic [2:0]       reg_f,
  input  logic [2:0]       rm_f,
  input  logic             wide,
  input  logic [AW-1:0]    disp,
  input  logic [2:0]       seg_ovr,
  input  logic [AW-1:0]    bx_v,
  input  logic [AW-1:0]    bp_v,
  input  logic [AW-1:0]    si_v,
  input  logic [AW-1:0]    di_v,
  input  logic [AW-1:0]    ds_v,
  input  logic [AW-1:0]    ss_v,
  input  logic [AW-1:0]    es_v,
  output logic             out_valid,
  output logic             is_mem,
  output logic [AW-1:0]    ea,
  output logic [1:0]       seg_id,
  output logic [AW+SH-1:0] phys,
  output logic [SW-1:0]    reg_code,
  output logic             reg_hi,
  output logic [SW-1:0]    rm_code,
  output logic             rm_hi
);
  localparam int PW = AW + SH;

  function automatic logic [PW-1:0] phys_of(input logic [AW-1:0] s, input logic [AW-1:0] e);
    return {s, {SH{1'b0}}} + {{SH{1'b0}}, e};
  endfunction

  logic          c_is_mem, c_bp_used;
  logic [AW-1:0] c_ea, c_seg_val;
  seg_e          c_seg;
  logic [PW-1:0] c_phys;
  logic [SW-1:0] c_code [2];
  logic          c_hi   [2];
  logic [SW-1:0] dec_field [2];
  logic          dec_en    [2];

  ea_calc #(.AW(AW)) u_calc (
    .mode(mode), .rm_f(rm_f), .disp(disp),
    .bx_v(bx_v), .bp_v(bp_v), .si_v(si_v), .di_v(di_v),
    .is_mem(c_is_mem), .bp_used(c_bp_used), .ea(c_ea)
  );

  seg_pick #(.AW(AW)) u_seg (
    .is_mem(c_is_mem), .bp_used(c_bp_used), .seg_ovr(seg_ovr),
    .ds_v(ds_v), .ss_v(ss_v), .es_v(es_v),
    .seg_id(c_seg), .seg_val(c_seg_val)
  );

  assign dec_field[0] = reg_f;
  assign dec_en[0]    = 1'b1;
  assign dec_field[1] = rm_f;
  assign dec_en[1]    = !c_is_mem;

  for (genvar g = 0; g < 2; g++) begin : g_dec
    reg_decode #(.SW(SW)) u_dec (
      .en(dec_en[g]), .wide(wide), .field(dec_field[g]),
      .code(c_code[g]), .hi(c_hi[g])
    );
  end

  assign c_phys = c_is_mem ? phys_of(c_seg_val, c_ea) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      is_mem    <= 1'b0;
      ea        <= '0;
      seg_id    <= 2'd0;
      phys      <= '0;
      reg_code  <= '0;
      reg_hi    <= 1'b0;
      rm_code   <= '0;
      rm_hi     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        is_mem   <= c_is_mem;
        ea       <= c_ea;
        seg_id   <= c_seg;
        phys     <= c_phys;
        reg_code <= c_code[0];
        reg_hi   <= c_hi[0];
        rm_code  <= c_code[1];
        rm_hi    <= c_hi[1];
      end
    end
  end

  a_r1_reg_form: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd3) |=> (!is_mem && ea == '0 && phys == '0));
  a_r4_direct_ds: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd0 && rm_f == 3'd6 && seg_ovr == 3'b000) |-> (c_seg == SEG_DS && c_ea == disp));
  a_r5_bp_stack: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && c_bp_used && seg_ovr == 3'b000) |-> c_seg == SEG_SS);
  a_r6_es_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && c_is_mem && seg_ovr[2]) |-> c_seg == SEG_ES);
  a_r6_regform_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !c_is_mem) |-> c_seg == SEG_DS);
  a_r8_byte_low_code: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide) |-> !c_code[0][SW-1]);
  a_r9_mem_no_rm: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && c_is_mem) |-> (c_code[1] == '0 && !c_hi[1]));
  a_r10_valid_on: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(ea) && $stable(phys) && $stable(seg_id)));
endmodule

// File: tb/test_modrm_ea_stage.sv
module test_modrm_ea_stage;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] mode = '0;
  logic [2:0] reg_f = '0, rm_f = '0, seg_ovr = '0;
  logic wide = 1'b0;
  logic [15:0] disp = '0, bx_v = '0, bp_v = '0, si_v = '0, di_v = '0;
  logic [15:0] ds_v = '0, ss_v = '0, es_v = '0;
  logic out_valid, is_mem, reg_hi, rm_hi;
  logic [15:0] ea;
  logic [1:0] seg_id;
  logic [19:0] phys;
  logic [2:0] reg_code, rm_code;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  modrm_ea_stage i_modrm_ea_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .reg_f(reg_f),
    .rm_f(rm_f), .wide(wide), .disp(disp), .seg_ovr(seg_ovr),
    .bx_v(bx_v), .bp_v(bp_v), .si_v(si_v), .di_v(di_v),
    .ds_v(ds_v), .ss_v(ss_v), .es_v(es_v),
    .out_valid(out_valid), .is_mem(is_mem), .ea(ea), .seg_id(seg_id),
    .phys(phys), .reg_code(reg_code), .reg_hi(reg_hi),
    .rm_code(rm_code), .rm_hi(rm_hi)
  );

  logic        x_mem, x_rh, x_mh;
  logic [15:0] x_ea;
  logic [1:0]  x_seg;
  logic [19:0] x_phys;
  logic [2:0]  x_rc, x_mc;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model();
    int sum, segv;
    bit bp_b;
    sum = 0; bp_b = 0;
    x_mem = (mode != 2'd3);
    if (rm_f == 3'd0 || rm_f == 3'd1 || rm_f == 3'd7) sum += bx_v;
    if (rm_f == 3'd2 || rm_f == 3'd3 || (rm_f == 3'd6 && mode != 2'd0)) begin
      sum += bp_v; bp_b = 1;
    end
    if (rm_f == 3'd0 || rm_f == 3'd2 || rm_f == 3'd4) sum += si_v;
    if (rm_f == 3'd1 || rm_f == 3'd3 || rm_f == 3'd5) sum += di_v;
    if (mode == 2'd1) sum += (disp[7] ? int'(disp[7:0]) - 256 : int'(disp[7:0]));
    if (mode == 2'd2) sum += disp;
    if (mode == 2'd0 && rm_f == 3'd6) sum = disp;
    x_ea = x_mem ? sum[15:0] : 16'h0;
    if (!x_mem) x_seg = 2'd0;
    else if (seg_ovr[2]) x_seg = 2'd2;
    else if (seg_ovr[1]) x_seg = 2'd1;
    else if (seg_ovr[0]) x_seg = 2'd0;
    else x_seg = bp_b ? 2'd1 : 2'd0;
    segv = (x_seg == 2'd2) ? es_v : (x_seg == 2'd1) ? ss_v : ds_v;
    sum = segv * 16 + x_ea;
    x_phys = x_mem ? sum[19:0] : 20'h0;
    x_rc = wide ? reg_f : {1'b0, reg_f[1:0]};
    x_rh = wide ? 1'b0 : reg_f[2];
    x_mc = x_mem ? 3'd0 : (wide ? rm_f : {1'b0, rm_f[1:0]});
    x_mh = x_mem ? 1'b0 : (wide ? 1'b0 : rm_f[2]);
  endtask

  task automatic compare(input string note);
    chk(out_valid === 1'b1, "R10 out_valid", out_valid, 1);
    chk(is_mem === x_mem, "R1 is_mem", is_mem, x_mem);
    chk(ea === x_ea, (mode == 2'd1 || mode == 2'd2) ? "R3 ea" : (mode == 2'd0 && rm_f == 3'd6) ? "R4 ea" : "R2 ea", ea, x_ea);
    chk(seg_id === x_seg, (seg_ovr != 0) ? "R6 seg" : "R5 seg", seg_id, x_seg);
    chk(phys === x_phys, "R7 phys", phys, x_phys);
    chk(reg_code === x_rc && reg_hi === x_rh, "R8 reg decode", {reg_hi, reg_code}, {x_rh, x_rc});
    chk(rm_code === x_mc && rm_hi === x_mh, "R9 rm decode", {rm_hi, rm_code}, {x_mh, x_mc});
    if (errors != 0 && note != "") ;
  endtask

  task automatic run_valid();
    in_valid = 1'b1;
    model();
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    compare("");
  endtask

  task automatic set_ops(input logic [1:0] m, input logic [2:0] r, input logic [2:0] q,
                         input logic w, input logic [15:0] d, input logic [2:0] o);
    mode = m; reg_f = r; rm_f = q; wide = w; disp = d; seg_ovr = o;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(out_valid === 1'b0 && ea === 16'h0 && phys === 20'h0 && is_mem === 1'b0,
        "R11 reset outputs", {out_valid, is_mem}, 0);
    rst_n = 1'b1;
    bx_v = 16'h1000; bp_v = 16'h2000; si_v = 16'h0030; di_v = 16'h0400;
    ds_v = 16'h1111; ss_v = 16'h2222; es_v = 16'h3333;

    // R4 direct address, data segment
    set_ops(2'd0, 3'd0, 3'd6, 1'b1, 16'h7000, 3'b000); run_valid();
    // R4 direct address with extra override
    set_ops(2'd0, 3'd0, 3'd6, 1'b1, 16'h7000, 3'b100); run_valid();
    // R3 R5 BP with negative 8-bit displacement -> stack
    set_ops(2'd1, 3'd2, 3'd6, 1'b1, 16'h00F6, 3'b000); run_valid();
    chk(ea === 16'h1FF6, "R3 sext8 negative", ea, 16'h1FF6);
    chk(seg_id === 2'd1, "R5 bp default stack", seg_id, 1);
    // R6 data override on BP form
    set_ops(2'd2, 3'd1, 3'd3, 1'b1, 16'h0010, 3'b001); run_valid();
    // R6 multiple bits: highest wins
    set_ops(2'd0, 3'd1, 3'd2, 1'b1, 16'h0000, 3'b111); run_valid();
    chk(seg_id === 2'd2, "R6 priority", seg_id, 2);
    set_ops(2'd0, 3'd1, 3'd7, 1'b1, 16'h0000, 3'b011); run_valid();
    // R2 wrap of base+index
    bx_v = 16'hFFFF; si_v = 16'h0002;
    set_ops(2'd0, 3'd0, 3'd0, 1'b1, 16'h0000, 3'b000); run_valid();
    chk(ea === 16'h0001, "R2 wrap", ea, 1);
    // R7 physical wrap
    ds_v = 16'hFFFF; bx_v = 16'h0020;
    set_ops(2'd0, 3'd0, 3'd7, 1'b1, 16'h0000, 3'b000); run_valid();
    chk(phys === 20'h00010, "R7 phys wrap", phys, 20'h10);
    // R1 R6 register form ignores override
    set_ops(2'd3, 3'd4, 3'd7, 1'b0, 16'hABCD, 3'b100); run_valid();
    chk(seg_id === 2'd0 && rm_hi === 1'b1 && rm_code === 3'd3, "R9 rm byte", {rm_hi, rm_code}, 4'hB);
    // R8 byte upper half
    chk(reg_hi === 1'b1 && reg_code === 3'd0, "R8 byte hi", {reg_hi, reg_code}, 4'h8);

    // R10 hold on idle with changed inputs
    model();
    begin
      logic [15:0] h_ea; logic [19:0] h_ph; logic [1:0] h_sg;
      h_ea = ea; h_ph = phys; h_sg = seg_id;
      set_ops(2'd2, 3'd5, 3'd1, 1'b1, 16'h5555, 3'b100);
      @(posedge clk); @(negedge clk);
      chk(out_valid === 1'b0, "R10 idle valid", out_valid, 0);
      chk(ea === h_ea && phys === h_ph && seg_id === h_sg, "R10 hold", ea, h_ea);
    end

    // Random phase
    for (int i = 0; i < 400; i++) begin
      bx_v = $urandom; bp_v = $urandom; si_v = $urandom; di_v = $urandom;
      ds_v = $urandom; ss_v = $urandom; es_v = $urandom;
      set_ops(2'($urandom), 3'($urandom), 3'($urandom), 1'($urandom), 16'($urandom),
              ($urandom % 4 == 0) ? 3'($urandom) : 3'b000);
      run_valid();
      if (i % 37 == 0) begin
        @(posedge clk); @(negedge clk);
        chk(out_valid === 1'b0, "R10 gap", out_valid, 0);
      end
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule